// File: doc/BRIEF.md
# NIC control and status register block

This block is the host-facing control window of a simple network controller. Software reaches it through a word-addressed register port with byte lanes. Through that port it issues commands to two internal engines: a transmit/command engine and a receive engine. It also reads and acknowledges pending event flags, loads a general address pointer that the engines consume, and posts a one-shot port operation. The engines are outside this block. They appear here as a command/valid/accept handshake, a set of event strobes and a pair of state inputs.

A command written into either field is offered to its engine until the engine accepts it. One cycle after acceptance the field reads back as zero. Software polls for that zero before it issues the next command. Event flags collect in the upper status byte and are cleared by writing ones. They drive a single interrupt line that software can mask, and software can also raise the interrupt on purpose.

Top module: `nic_ctl_block`

## Requirements
- R1: After reset the upper status byte, both command fields, the mask bit, the pointer and the interrupt are all zero, and no command or port strobe is offered.
- R2: An event strobe on `evt_i[k]` sets status bit 8+k of word 0 on the next clock. Status bit 9 (k=1) is reserved: it never sets and always reads 0.
- R3: A write to word 0 with lane 1 enabled clears each status bit 15:8 where `wdata_i` has a 1 and leaves the others unchanged. When an event and a clear hit the same bit in the same cycle, the bit stays set.
- R4: Word 0 bits 7:6 reflect `cu_state_i`, bits 5:2 reflect `ru_state_i` (for example 4'b1001 is suspended with no buffer descriptors), and bits 1:0 read 0. Writes through lane 0 of word 0 have no effect.
- R5: The command-engine field is written through word 0 bits 23:20 (lane 2). A nonzero value is driven on `cu_cmd_o` with `cu_valid_o` high and held until `cu_accept_i`. The field is zero on the next clock after acceptance, and it reads back zero.
- R6: The receive-engine field is written through word 0 bits 18:16 (lane 2). It follows the same handshake on `ru_cmd_o`/`ru_valid_o`/`ru_accept_i`, independently of the command-engine field.
- R7: Word 0 bit 24 (lane 3) is the interrupt mask. `irq_o` is high when any status bit 15:8 is set and the mask is 0.
- R8: Writing 1 to word 0 bit 25 (lane 3) sets status bit 10 on the next clock. While bit 10 is set, `irq_o` is high even when the mask is 1. Bit 25 always reads 0.
- R9: Word 1 holds the general pointer. Each byte lane enabled in a write updates its byte. The value reads back and is driven on `ptr_o`.
- R10: A write to word 2 with all four lanes enabled raises `port_valid_o` for exactly one cycle on the next clock, carrying the written value on `port_data_o`. Partial-lane writes to word 2 are ignored. Word 2 reads 0.
- R11: With `RD_REG`=1, `rdata_o` presents the addressed word on the clock after `rd_en_i` and holds it until the next read. With `RD_REG`=0 it is combinational.
- R12: If a host write to a command field coincides with that engine's accept, the written value wins and is offered next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| addr_i | input | ADDR_W | Word address (0 control/status, 1 pointer, 2 port) |
| wdata_i | input | 32 | Host write data |
| be_i | input | 4 | Byte lane enables |
| rdata_o | output | 32 | Host read data |
| irq_o | output | 1 | Interrupt request |
| cu_cmd_o | output | 4 | Command-engine command |
| cu_valid_o | output | 1 | Command-engine command pending |
| cu_accept_i | input | 1 | Command engine takes the command |
| ru_cmd_o | output | 3 | Receive-engine command |
| ru_valid_o | output | 1 | Receive-engine command pending |
| ru_accept_i | input | 1 | Receive engine takes the command |
| ptr_o | output | PTR_W | General pointer value |
| cu_state_i | input | 2 | Command-engine state |
| ru_state_i | input | 4 | Receive-engine state |
| evt_i | input | 8 | Event strobes for status bits 15:8 |
| port_valid_o | output | 1 | One-cycle port operation strobe |
| port_data_o | output | 32 | Port operation operand |

## Verification
The bench builds the block with `RD_REG`=1, `PTR_W`=32 and `ADDR_W`=3. This puts the registered read path under test, including its one-cycle latency and its hold between reads. It also makes every pointer byte lane reachable, so mixed-lane pointer writes can be checked, and leaves spare word addresses on the bus. The combinational read variant is not built by this bench.

// File: rtl/nicctl_pkg.sv
package nicctl_pkg;
   // word addresses inside the register window
   localparam int OFS_CTRL = 0;
   localparam int OFS_PTR  = 1;
   localparam int OFS_PORT = 2;
   // command field widths, fixed by the word-0 layout
   localparam int CU_W = 4;
   localparam int RU_W = 3;
   // upper status byte: bit 1 (status bit 9) is reserved
   localparam logic [7:0] EVT_KEEP = 8'hFD;
   // position of the software-interrupt flag inside the upper byte
   localparam int SWI_IDX = 2;
endpackage

// File: rtl/nicctl_status.sv
module nicctl_status
   import nicctl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] evt_i,
   input  logic       clr_en_i,
   input  logic [7:0] clr_bits_i,
   input  logic       swi_set_i,
   input  logic       mask_i,
   output logic [7:0] pend_o,
   output logic       irq_o
);
   logic [7:0] pend_q;
   logic [7:0] set_v;
   logic [7:0] clr_v;

   always_comb begin
      set_v = evt_i & EVT_KEEP;
      set_v[SWI_IDX] = set_v[SWI_IDX] | swi_set_i;
      clr_v = clr_en_i ? clr_bits_i : 8'h00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= ((pend_q & ~clr_v) | set_v) & EVT_KEEP;
   end

   assign pend_o = pend_q;
   assign irq_o  = ((|pend_q) & ~mask_i) | pend_q[SWI_IDX];

   AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_v != 8'h00) |=> ((pend_q & $past(set_v)) == $past(set_v))); // R3
   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_v != 8'h00) |=> ((pend_q & $past(clr_v & ~set_v)) == 8'h00)); // R3
   AST_RSVD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i[1]) |=> !pend_q[1]); // R2
endmodule

// File: rtl/nicctl_cmdfield.sv
module nicctl_cmdfield #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   input  logic         acc_i,
   output logic [W-1:0] cmd_o,
   output logic         valid_o
);
   logic [W-1:0] cmd_q;

   if (W < 1 || W > 8) begin : g_bad_w
      $error("nicctl_cmdfield: W must be 1..8");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cmd_q <= '0;
      else if (wr_i)              cmd_q <= wdata_i;
      else if (valid_o && acc_i)  cmd_q <= '0;
   end

   assign cmd_o   = cmd_q;
   assign valid_o = (cmd_q != '0);

   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !acc_i && !wr_i) |=> $stable(cmd_o)); // R5 R6
   AST_CMD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && acc_i && !wr_i) |=> !valid_o); // R5 R6
   AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i) |=> (cmd_o == $past(wdata_i))); // R12
endmodule

// File: rtl/nic_ctl_block.sv
module nic_ctl_block
   import nicctl_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int PTR_W  = 32,
   parameter int RD_REG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   input  logic [3:0]        be_i,
   output logic [31:0]       rdata_o,
   output logic              irq_o,
   output logic [CU_W-1:0]   cu_cmd_o,
   output logic              cu_valid_o,
   input  logic              cu_accept_i,
   output logic [RU_W-1:0]   ru_cmd_o,
   output logic              ru_valid_o,
   input  logic              ru_accept_i,
   output logic [PTR_W-1:0]  ptr_o,
   input  logic [1:0]        cu_state_i,
   input  logic [3:0]        ru_state_i,
   input  logic [7:0]        evt_i,
   output logic              port_valid_o,
   output logic [31:0]       port_data_o
);
   localparam int PTR_BYTES = PTR_W / 8;
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_PTR  = ADDR_W'(OFS_PTR);
   localparam logic [ADDR_W-1:0] A_PORT = ADDR_W'(OFS_PORT);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("nic_ctl_block: ADDR_W must reach three words");
   end
   if (PTR_W < 8 || PTR_W > 32 || (PTR_W % 8) != 0) begin : g_bad_ptr
      $error("nic_ctl_block: PTR_W must be 8, 16, 24 or 32");
   end
   if (RD_REG != 0 && RD_REG != 1) begin : g_bad_rd
      $error("nic_ctl_block: RD_REG must be 0 or 1");
   end

   // ---------------- decode ----------------
   logic wr_ctl, wr_ptr, wr_port;
   assign wr_ctl  = wr_en_i && (addr_i == A_CTRL);
   assign wr_ptr  = wr_en_i && (addr_i == A_PTR);
   assign wr_port = wr_en_i && (addr_i == A_PORT) && (be_i == 4'hF);

   // ---------------- control word fields ----------------
   logic       mask_q;
   logic       swi_set;
   logic [7:0] pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  mask_q <= 1'b0;
      else if (wr_ctl && be_i[3])  mask_q <= wdata_i[24];
   end
   assign swi_set = wr_ctl && be_i[3] && wdata_i[25];

   nicctl_status u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt_i),
      .clr_en_i   (wr_ctl && be_i[1]),
      .clr_bits_i (wdata_i[15:8]),
      .swi_set_i  (swi_set),
      .mask_i     (mask_q),
      .pend_o     (pend),
      .irq_o      (irq_o)
   );

   nicctl_cmdfield #(.W(CU_W)) u_cu (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_ctl && be_i[2]),
      .wdata_i (wdata_i[23:20]),
      .acc_i   (cu_accept_i),
      .cmd_o   (cu_cmd_o),
      .valid_o (cu_valid_o)
   );

   nicctl_cmdfield #(.W(RU_W)) u_ru (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_ctl && be_i[2]),
      .wdata_i (wdata_i[18:16]),
      .acc_i   (ru_accept_i),
      .cmd_o   (ru_cmd_o),
      .valid_o (ru_valid_o)
   );

   // ---------------- pointer, one register per byte lane ----------------
   logic [PTR_W-1:0] ptr_q;
   for (genvar g = 0; g < PTR_BYTES; g++) begin : g_ptr_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  ptr_q[g*8 +: 8] <= 8'h00;
         else if (wr_ptr && be_i[g])  ptr_q[g*8 +: 8] <= wdata_i[g*8 +: 8];
      end
   end
   assign ptr_o = ptr_q;

   // ---------------- port strobe ----------------
   logic        port_v_q;
   logic [31:0] port_d_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_v_q <= 1'b0;
         port_d_q <= '0;
      end else begin
         port_v_q <= wr_port;
         if (wr_port) port_d_q <= wdata_i;
      end
   end
   assign port_valid_o = port_v_q;
   assign port_data_o  = port_d_q;

   // ---------------- read path ----------------
   logic [31:0] word0;
   logic [31:0] rd_mux;
   assign word0 = {6'b0, 1'b0, mask_q, cu_cmd_o, 1'b0, ru_cmd_o,
                   pend, cu_state_i, ru_state_i, 2'b00};

   always_comb begin
      if (addr_i == A_CTRL)     rd_mux = word0;
      else if (addr_i == A_PTR) rd_mux = 32'(ptr_q);
      else                      rd_mux = 32'h0;
   end

   if (RD_REG == 1) begin : g_rd_reg
      logic [31:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       rdata_q <= '0;
         else if (rd_en_i) rdata_q <= rd_mux;
      end
      assign rdata_o = rdata_q;
   end else begin : g_rd_comb
      assign rdata_o = rd_en_i ? rd_mux : 32'h0;
   end

   // ---------------- checks at the block boundary ----------------
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q && !pend[SWI_IDX]) |-> !irq_o); // R7
   AST_SWI_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (swi_set) |=> irq_o); // R8
   AST_PORT_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (port_valid_o) |-> $past(wr_en_i && be_i == 4'hF)); // R10
endmodule

// File: tb/nic_ctl_block_tb_top.sv
`timescale 1ns/1ps
module nic_ctl_block_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [3:0]  be = '0;
   logic [31:0] rdata;
   logic        irq;
   logic [3:0]  cu_cmd;
   logic        cu_valid, cu_acc = 1'b0;
   logic [2:0]  ru_cmd;
   logic        ru_valid, ru_acc = 1'b0;
   logic [31:0] ptr;
   logic [1:0]  cu_state = '0;
   logic [3:0]  ru_state = '0;
   logic [7:0]  evt = '0;
   logic        port_valid;
   logic [31:0] port_data;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_seen = 1'b0;

   always #10 clk = ~clk;

   nic_ctl_block #(.ADDR_W(3), .PTR_W(32), .RD_REG(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .addr_i(addr), .wdata_i(wdata), .be_i(be), .rdata_o(rdata),
      .irq_o(irq), .cu_cmd_o(cu_cmd), .cu_valid_o(cu_valid),
      .cu_accept_i(cu_acc), .ru_cmd_o(ru_cmd), .ru_valid_o(ru_valid),
      .ru_accept_i(ru_acc), .ptr_o(ptr), .cu_state_i(cu_state),
      .ru_state_i(ru_state), .evt_i(evt), .port_valid_o(port_valid),
      .port_data_o(port_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: registered read data is valid one clock after the strobe
   always @(posedge clk) rd_seen <= rd_en;
   always @(negedge clk) begin
      if (rd_seen && exp_q.size() > 0) begin
         chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
   end

   task automatic do_wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] b);
      wr_en = 1'b1; addr = a; wdata = d; be = b;
      @(negedge clk);
      wr_en = 1'b0; be = '0;
   endtask

   task automatic do_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
      rd_en = 1'b1; addr = a;
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic pulse_evt(input logic [7:0] e);
      evt = e;
      @(negedge clk);
      evt = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", 32'(irq), 0);
      chk("R1 cu_valid", 32'(cu_valid), 0);
      chk("R1 ru_valid", 32'(ru_valid), 0);
      chk("R1 port_valid", 32'(port_valid), 0);
      chk("R1 ptr", ptr, 0);
      do_rd(3'd0, 32'h0, "R1 word0");

      // R4 engine state fields, lane 0 writes ignored
      cu_state = 2'b10; ru_state = 4'b1001;
      @(negedge clk);
      do_rd(3'd0, 32'h0000_00A4, "R4 state");
      do_wr(3'd0, 32'h0000_00FF, 4'b0001);
      do_rd(3'd0, 32'h0000_00A4, "R4 lane0 ignored");

      // R2 all events, reserved bit stays 0
      pulse_evt(8'hFF);
      chk("R2 irq", 32'(irq), 1);
      do_rd(3'd0, 32'h0000_FDA4, "R2 pend");

      // R3 write-one-to-clear
      do_wr(3'd0, 32'h0000_8100, 4'b0010);
      do_rd(3'd0, 32'h0000_7CA4, "R3 partial clear");
      evt = 8'h40;
      do_wr(3'd0, 32'h0000_4000, 4'b0010);
      evt = '0;
      do_rd(3'd0, 32'h0000_7CA4, "R3 event wins");
      do_wr(3'd0, 32'h0000_FF00, 4'b0010);
      chk("R3 irq off", 32'(irq), 0);
      do_rd(3'd0, 32'h0000_00A4, "R3 all clear");

      // R7 mask
      do_wr(3'd0, 32'h0100_0000, 4'b1000);
      pulse_evt(8'h08);
      chk("R7 masked", 32'(irq), 0);
      do_rd(3'd0, 32'h0100_08A4, "R7 readback");
      do_wr(3'd0, 32'h0000_0000, 4'b1000);
      chk("R7 unmasked", 32'(irq), 1);
      do_wr(3'd0, 32'h0000_0800, 4'b0010);
      chk("R7 cleared", 32'(irq), 0);

      // R8 software interrupt beats the mask
      do_wr(3'd0, 32'h0300_0000, 4'b1000);
      chk("R8 swi irq", 32'(irq), 1);
      do_rd(3'd0, 32'h0100_04A4, "R8 readback");
      do_wr(3'd0, 32'h0000_0400, 4'b0010);
      chk("R8 swi cleared", 32'(irq), 0);
      do_wr(3'd0, 32'h0000_0000, 4'b1000);

      // R5 command-engine handshake
      do_wr(3'd0, 32'h0010_0000, 4'b0100);
      chk("R5 cu valid", 32'(cu_valid), 1);
      chk("R5 cu cmd", 32'(cu_cmd), 1);
      chk("R5 ru idle", 32'(ru_valid), 0);
      repeat (3) @(negedge clk);
      chk("R5 cu held", 32'(cu_cmd), 1);
      do_rd(3'd0, 32'h0010_00A4, "R5 busy readback");
      cu_acc = 1'b1; @(negedge clk); cu_acc = 1'b0;
      chk("R5 cu cleared", 32'(cu_valid), 0);
      do_rd(3'd0, 32'h0000_00A4, "R5 zero readback");
      do_wr(3'd0, 32'h0070_0000, 4'b0100);
      chk("R5 cu cmd 7", 32'(cu_cmd), 7);
      cu_acc = 1'b1; @(negedge clk); cu_acc = 1'b0;

      // R6 receive-engine field, independent acceptance
      do_wr(3'd0, 32'h0054_0000, 4'b0100);
      chk("R6 ru cmd", 32'(ru_cmd), 4);
      chk("R6 ru valid", 32'(ru_valid), 1);
      ru_acc = 1'b1; @(negedge clk); ru_acc = 1'b0;
      chk("R6 ru cleared", 32'(ru_valid), 0);
      chk("R6 cu kept", 32'(cu_cmd), 5);
      cu_acc = 1'b1; @(negedge clk); cu_acc = 1'b0;
      chk("R6 cu then cleared", 32'(cu_valid), 0);

      // R12 write coinciding with accept
      do_wr(3'd0, 32'h0020_0000, 4'b0100);
      cu_acc = 1'b1;
      do_wr(3'd0, 32'h0060_0000, 4'b0100);
      cu_acc = 1'b0;
      chk("R12 new cmd", 32'(cu_cmd), 6);
      cu_acc = 1'b1; @(negedge clk); cu_acc = 1'b0;

      // R9 pointer lanes
      do_wr(3'd1, 32'h1234_5678, 4'b1111);
      chk("R9 ptr_o", ptr, 32'h1234_5678);
      do_wr(3'd1, 32'hAABB_CCDD, 4'b0101);
      do_rd(3'd1, 32'h12BB_56DD, "R9 lanes");

      // R10 port strobe
      wr_en = 1'b1; addr = 3'd2; wdata = 32'hDEAD_BEEF; be = 4'hF;
      @(negedge clk);
      wr_en = 1'b0; be = '0;
      chk("R10 strobe", 32'(port_valid), 1);
      chk("R10 data", port_data, 32'hDEAD_BEEF);
      @(negedge clk);
      chk("R10 one cycle", 32'(port_valid), 0);
      do_wr(3'd2, 32'h0000_1111, 4'b0011);
      chk("R10 partial ignored", 32'(port_valid), 0);
      do_rd(3'd2, 32'h0, "R10 reads zero");

      // R11 registered read holds between reads
      do_rd(3'd1, 32'h12BB_56DD, "R11 latency");
      repeat (3) @(negedge clk);
      chk("R11 hold", rdata, 32'h12BB_56DD);

      repeat (2) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule